// File: doc/BRIEF.md
# Flash Program/Erase Error Guard

This block watches a flash program or erase session and raises a sticky error flag when a forbidden system event happens while the array is being written. Four events count: a read of the flash array, an unexcluded hardware exception right at the start of a session, a request for a sleep-type low-power state, and a bus release. Once the flag is up, every per-block program/erase enable is forced low. Only a reset or entry into hardware standby brings it back down.

The block also holds a small control/status byte. It carries the error flag, a RAM-overlay select bit and a three-bit area field that, together with the select bit, chooses which flash area is replaced by RAM so that updates can be emulated. While the select bit is set, all blocks are write/erase-protected and the overlay-active output is high. Array read data that passes through the block is replaced by a fixed poison word whenever a session is running. This makes an illegal read visible in the data as well.

Top module: `fpe_guard`

## Requirements
- R1: After reset the control byte reads 0x70, overlay_active is 0, and no enable is active while no block requests one.
- R2: An array read (arr_rd=1 with ovl_hit=0) in a cycle where prog_act or erase_act is 1 sets bit 7 of the control byte from the next cycle on. A read with ovl_hit=1, or a read outside a session, leaves bit 7 at 0.
- R3: An exception strobe (exc_entry=1 with exc_excluded=0) sets bit 7 when it occurs in the first cycle of a session, or in the cycle just before that first cycle. Excluded exceptions, and exceptions at any other time, do not set it.
- R4: sleep_req=1 or bus_rel=1 during a session sets bit 7 from the next cycle. Outside a session neither has any effect.
- R5: Once set, bit 7 stays set through any number of later cycles and register writes, including writes of bit 7 = 0.
- R6: hw_stby=1 at a clock edge returns the whole control byte to 0x70, clearing bit 7, bit 3 and bits 2..0. It takes priority over a set event or a write in the same cycle.
- R7: Bits 6..4 always read 1 and ignore writes. Bits 3..0 take wdata[3:0] on the edge where reg_we=1.
- R8: blk_pe_en[i] equals blk_pe_req[i] AND NOT bit 7 AND NOT bit 3, with no clock delay.
- R9: ovl_active equals bit 3 of the control byte.
- R10: While prog_act or erase_act is 1, arr_rdata_out is the constant POISON (default 16'hDEAD). Otherwise it is arr_rdata_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby entry; clears the control byte |
| prog_act | input | 1 | Program operation in progress |
| erase_act | input | 1 | Erase operation in progress |
| arr_rd | input | 1 | Flash read strobe (data, vector or instruction fetch) |
| ovl_hit | input | 1 | Current read targets the RAM overlay area |
| exc_entry | input | 1 | Hardware exception sequence strobe |
| exc_excluded | input | 1 | Exception is of an exempt kind |
| sleep_req | input | 1 | Sleep or software-standby request |
| bus_rel | input | 1 | Bus released to another master |
| reg_we | input | 1 | Control byte write strobe |
| reg_wdata | input | 8 | Control byte write data |
| reg_rdata | output | 8 | Control byte read value |
| blk_pe_req | input | NBLK | Requested per-block program/erase enables |
| blk_pe_en | output | NBLK | Granted per-block program/erase enables |
| ovl_active | output | 1 | RAM overlay in effect |
| arr_rdata_in | input | DW | Read data from the flash array |
| arr_rdata_out | output | DW | Read data as seen by the bus |

## Verification
The exception window is the sharpest corner. The bench places a strobe one cycle before the session start, in the start cycle, two cycles before, and in the second session cycle. A design with the window off by one either misses a legal trigger or flags a harmless exception. Overlay reads, excluded exceptions and out-of-session sleep or bus release are driven to catch a guard that ignores its qualifiers and sets the flag falsely. Writes of 0 to bit 7 after an error catch a flag that software can clear. Standby colliding with a set event or a write catches a wrong priority, which would leave the byte at something other than 0x70.

// File: rtl/fpe_guard_pkg.sv
package fpe_guard_pkg;
  localparam int AREA_W = 3;
  localparam logic [2:0] RSVD_ONES = 3'b111;

  typedef struct packed {
    logic rd_err;
    logic exc_err;
    logic slp_err;
    logic bus_err;
  } err_src_t;

  function automatic logic any_err(input err_src_t s);
    return s.rd_err | s.exc_err | s.slp_err | s.bus_err;
  endfunction

  function automatic logic [7:0] pack_ctrl(input logic flag, input logic ramsel,
                                           input logic [AREA_W-1:0] area);
    return {flag, RSVD_ONES, ramsel, area};
  endfunction

  function automatic logic grant(input logic req, input logic flag, input logic ramsel);
    return req & ~flag & ~ramsel;
  endfunction
endpackage

// File: rtl/fpe_err_detect.sv
module fpe_err_detect
  import fpe_guard_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hw_stby,
  input  logic     session,
  input  logic     arr_rd,
  input  logic     ovl_hit,
  input  logic     exc_entry,
  input  logic     exc_excluded,
  input  logic     sleep_req,
  input  logic     bus_rel,
  output logic     session_start,
  output err_src_t err_src,
  output logic     err_flag
);
  logic session_q;
  logic exc_q;
  logic exc_now;

  assign exc_now       = exc_entry & ~exc_excluded;
  assign session_start = session & ~session_q;

  always_comb begin
    err_src.rd_err  = session & arr_rd & ~ovl_hit;
    err_src.exc_err = session_start & (exc_now | exc_q);
    err_src.slp_err = session & sleep_req;
    err_src.bus_err = session & bus_rel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      session_q <= 1'b0;
      exc_q     <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      session_q <= session;
      exc_q     <= exc_now;
      if (hw_stby)
        err_flag <= 1'b0;
      else if (any_err(err_src))
        err_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/fpe_ctrl_reg.sv
module fpe_ctrl_reg
  import fpe_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_stby,
  input  logic              we,
  input  logic [7:0]        wdata,
  output logic              ramsel,
  output logic [AREA_W-1:0] area
);
  logic [4:0] unused_wdata_hi;
  assign unused_wdata_hi = wdata[7:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramsel <= 1'b0;
      area   <= '0;
    end else if (hw_stby) begin
      ramsel <= 1'b0;
      area   <= '0;
    end else if (we) begin
      ramsel <= wdata[3];
      area   <= wdata[AREA_W-1:0];
    end
  end
endmodule

// File: rtl/fpe_pe_gate.sv
module fpe_pe_gate
  import fpe_guard_pkg::*;
#(
  parameter int NBLK = 8
) (
  input  logic [NBLK-1:0] req,
  input  logic            flag,
  input  logic            ramsel,
  output logic [NBLK-1:0] en
);
  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    assign en[i] = grant(req[i], flag, ramsel);
  end
endmodule

// File: rtl/fpe_guard.sv
module fpe_guard
  import fpe_guard_pkg::*;
#(
  parameter int          NBLK   = 8,
  parameter int          DW     = 16,
  parameter logic [DW-1:0] POISON = 16'hDEAD
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hw_stby,
  input  logic            prog_act,
  input  logic            erase_act,
  input  logic            arr_rd,
  input  logic            ovl_hit,
  input  logic            exc_entry,
  input  logic            exc_excluded,
  input  logic            sleep_req,
  input  logic            bus_rel,
  input  logic            reg_we,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic [NBLK-1:0] blk_pe_req,
  output logic [NBLK-1:0] blk_pe_en,
  output logic            ovl_active,
  input  logic [DW-1:0]   arr_rdata_in,
  output logic [DW-1:0]   arr_rdata_out
);
  logic              session;
  logic              session_start;
  err_src_t          err_src;
  logic              err_flag;
  logic              ramsel;
  logic [AREA_W-1:0] area;

  assign session = prog_act | erase_act;

  fpe_err_detect u_det (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_stby      (hw_stby),
    .session      (session),
    .arr_rd       (arr_rd),
    .ovl_hit      (ovl_hit),
    .exc_entry    (exc_entry),
    .exc_excluded (exc_excluded),
    .sleep_req    (sleep_req),
    .bus_rel      (bus_rel),
    .session_start(session_start),
    .err_src      (err_src),
    .err_flag     (err_flag)
  );

  fpe_ctrl_reg u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .hw_stby(hw_stby),
    .we     (reg_we),
    .wdata  (reg_wdata),
    .ramsel (ramsel),
    .area   (area)
  );

  fpe_pe_gate #(.NBLK(NBLK)) u_gate (
    .req   (blk_pe_req),
    .flag  (err_flag),
    .ramsel(ramsel),
    .en    (blk_pe_en)
  );

  assign reg_rdata     = pack_ctrl(err_flag, ramsel, area);
  assign ovl_active    = ramsel;
  assign arr_rdata_out = session ? POISON : arr_rdata_in;
endmodule

// File: rtl/fpe_guard_chk.sv
module fpe_guard_chk
  import fpe_guard_pkg::*;
#(
  parameter int            NBLK   = 8,
  parameter int            DW     = 16,
  parameter logic [DW-1:0] POISON = 16'hDEAD
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hw_stby,
  input logic            session,
  input logic            session_start,
  input logic            arr_rd,
  input logic            ovl_hit,
  input logic            sleep_req,
  input logic            bus_rel,
  input logic [7:0]      reg_rdata,
  input logic [NBLK-1:0] blk_pe_en,
  input logic            ovl_active,
  input logic [DW-1:0]   arr_rdata_out
);
  AST_READ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (session && arr_rd && !ovl_hit && !hw_stby) |=> reg_rdata[7]); // R2
  AST_START_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    session_start |=> !session_start); // R3
  AST_SLEEP_BUS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (session && (sleep_req || bus_rel) && !hw_stby) |=> reg_rdata[7]); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7] && !hw_stby) |=> reg_rdata[7]); // R5
  AST_STBY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (reg_rdata == 8'h70)); // R6
  AST_RSVD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[6:4] == 3'b111); // R7
  AST_PROTECT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7] || reg_rdata[3]) |-> (blk_pe_en == '0)); // R8
  AST_OVL_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_active == reg_rdata[3]); // R9
  AST_POISON: assert property (@(posedge clk) disable iff (!rst_n)
    session |-> (arr_rdata_out == POISON)); // R10
endmodule

bind fpe_guard fpe_guard_chk #(.NBLK(NBLK), .DW(DW), .POISON(POISON)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hw_stby      (hw_stby),
  .session      (session),
  .session_start(session_start),
  .arr_rd       (arr_rd),
  .ovl_hit      (ovl_hit),
  .sleep_req    (sleep_req),
  .bus_rel      (bus_rel),
  .reg_rdata    (reg_rdata),
  .blk_pe_en    (blk_pe_en),
  .ovl_active   (ovl_active),
  .arr_rdata_out(arr_rdata_out)
);

// File: tb/test_fpe_guard.sv
`timescale 1ns/1ps
module test_fpe_guard;
  localparam int NBLK = 8;
  localparam int DW   = 16;
  localparam logic [DW-1:0] PSN = 16'hDEAD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_stby = 0, prog_act = 0, erase_act = 0, arr_rd = 0, ovl_hit = 0;
  logic exc_entry = 0, exc_excluded = 0, sleep_req = 0, bus_rel = 0, reg_we = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [NBLK-1:0] blk_pe_req = '0;
  logic [NBLK-1:0] blk_pe_en;
  logic ovl_active;
  logic [DW-1:0] arr_rdata_in = '0;
  logic [DW-1:0] arr_rdata_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fpe_guard #(.NBLK(NBLK), .DW(DW), .POISON(PSN)) i_fpe_guard (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    prog_act = 0; erase_act = 0; arr_rd = 0; ovl_hit = 0; exc_entry = 0;
    exc_excluded = 0; sleep_req = 0; bus_rel = 0; reg_we = 0; hw_stby = 0;
  endtask

  task automatic standby();
    quiet();
    hw_stby = 1; tick(); hw_stby = 0;
  endtask

  task automatic t_reset();
    chk("R1", reg_rdata, 8'h70);
    chk("R1", ovl_active, 0);
    chk("R1", blk_pe_en, 0);
  endtask

  task automatic t_reg_rw();
    standby();
    reg_we = 1; reg_wdata = 8'h0D; tick(); reg_we = 0;
    chk("R7", reg_rdata, 8'h7D);
    chk("R9", ovl_active, 1);
    blk_pe_req = 8'hFF; #1;
    chk("R8", blk_pe_en, 8'h00);
    reg_we = 1; reg_wdata = 8'h85; tick(); reg_we = 0;
    chk("R7", reg_rdata, 8'h75);
    chk("R9", ovl_active, 0);
    chk("R8", blk_pe_en, 8'hFF);
    blk_pe_req = 8'h5A; #1;
    chk("R8", blk_pe_en, 8'h5A);
    blk_pe_req = '0;
  endtask

  task automatic t_read();
    standby();
    arr_rd = 1; arr_rdata_in = 16'h1234; #1;
    chk("R10", arr_rdata_out, 16'h1234);
    tick();
    chk("R2", reg_rdata[7], 0);
    prog_act = 1; ovl_hit = 1; #1;
    chk("R10", arr_rdata_out, PSN);
    tick();
    chk("R2", reg_rdata[7], 0);
    ovl_hit = 0; tick();
    chk("R2", reg_rdata[7], 1);
    quiet(); blk_pe_req = 8'hFF; #1;
    chk("R8", blk_pe_en, 8'h00);
    blk_pe_req = '0;
  endtask

  task automatic t_exc_window(input int lead, input logic excl, input logic exp);
    standby();
    for (int k = 0; k < 3; k++) tick();
    if (lead == 2) begin exc_entry = 1; exc_excluded = excl; tick(); exc_entry = 0; tick(); end
    if (lead == 1) begin exc_entry = 1; exc_excluded = excl; tick(); exc_entry = 0; end
    erase_act = 1;
    if (lead == 0) begin exc_entry = 1; exc_excluded = excl; end
    tick(); exc_entry = 0;
    if (lead == -1) begin exc_entry = 1; exc_excluded = excl; tick(); exc_entry = 0; end
    tick();
    chk("R3", reg_rdata[7], exp);
    quiet();
  endtask

  task automatic t_sleep_bus();
    standby();
    sleep_req = 1; bus_rel = 1; tick(); quiet(); tick();
    chk("R4", reg_rdata[7], 0);
    prog_act = 1; tick(); sleep_req = 1; tick(); quiet();
    chk("R4", reg_rdata[7], 1);
    standby();
    erase_act = 1; tick(); bus_rel = 1; tick(); quiet();
    chk("R4", reg_rdata[7], 1);
  endtask

  task automatic t_sticky_stby();
    for (int k = 0; k < 5; k++) tick();
    reg_we = 1; reg_wdata = 8'h00; tick(); reg_we = 0;
    chk("R5", reg_rdata[7], 1);
    reg_we = 1; reg_wdata = 8'h0B; tick(); reg_we = 0;
    chk("R5", reg_rdata, 8'hFB);
    prog_act = 1; arr_rd = 1; reg_we = 1; reg_wdata = 8'h0F; hw_stby = 1; tick();
    quiet();
    chk("R6", reg_rdata, 8'h70);
    chk("R6", ovl_active, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1;
    tick();
    t_reset();
    t_reg_rw();
    t_read();
    t_exc_window(1, 0, 1);
    t_exc_window(0, 0, 1);
    t_exc_window(2, 0, 0);
    t_exc_window(-1, 0, 0);
    t_exc_window(0, 1, 0);
    t_exc_window(1, 1, 0);
    t_sleep_bus();
    t_sticky_stby();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule